// File: doc/BRIEF.md
# CPU Interrupt Enable Controller

This block keeps the two interrupt-enable flip-flops of an 8-bit processor core and makes the acceptance decision for maskable and non-maskable interrupts at every instruction boundary. The instruction sequencer pulses `instrDone` in the cycle an instruction completes. In that cycle it also raises the decoded flag for the instruction that is completing, if that instruction affects interrupt state. The block turns these inputs into one-cycle accept strobes for the vector-fetch logic and into the parity/overflow bit for the "load accumulator from I/R" instruction.

Every decision is based on the enable state as the completing instruction leaves it. As a result, a DI takes effect at its own boundary. An EI opens the window only after one more instruction has finished. Taking a non-maskable interrupt saves the main enable into the shadow enable, and RETN brings it back. A parameter selects whether the parity/overflow bit has a known defect: with the defect enabled, the bit reads "disabled" when a maskable interrupt is taken at the end of the load.

Top module: `irq_enable_ctrl`

## Requirements
- R1: After reset, both enable flip-flops are clear, no NMI is latched, and `intAccept`, `nmiAccept` and `pvFlag` are all 0.
- R2: An EI sets the main and shadow enables. A maskable request is never accepted at the boundary that ends the EI. The earliest acceptance is at the boundary that ends the next instruction.
- R3: A DI clears both enables, and no maskable request is accepted at the boundary that ends the DI.
- R4: A maskable request is taken only at a boundary where `intReq` is 1 and the main enable is 1. Taking it gives a one-cycle `intAccept` pulse in the cycle after the boundary and clears both enables.
- R5: With `intReq` held at 1, a handler that ends with EI followed by RET lets exactly one instruction complete after the EI (the RET) before the next `intAccept`.
- R6: A rising edge on `nmiReq` latches one request, and holding the line high does not latch a second one. The latched request is taken at the next boundary regardless of the enables, gives a one-cycle `nmiAccept` pulse, and has priority over a maskable request at that boundary.
- R7: Taking an NMI copies the main enable into the shadow enable and clears the main enable.
- R8: RETN copies the shadow enable back into the main enable, so a maskable request can be taken at the RETN's own boundary.
- R9: On the boundary of a load from I/R (`isLdAir`), `pvFlag` takes the shadow enable as it stood before that boundary. The new value appears in the next cycle and is held until the next such load.
- R10: With `NMOS_BUG=1`, if a maskable request is accepted at the boundary of a load from I/R, `pvFlag` reads 0 for that load. With `NMOS_BUG=0` it reads the true shadow enable.
- R11: In cycles where `instrDone` is 0, the decoded flags and `intReq` have no effect: no strobe is given in the next cycle and the enable state does not change.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| instrDone | input | 1 | An instruction completes in this cycle (boundary) |
| isEi | input | 1 | The completing instruction is EI |
| isDi | input | 1 | The completing instruction is DI |
| isRetn | input | 1 | The completing instruction is RETN |
| isLdAir | input | 1 | The completing instruction loads A from I or R |
| intReq | input | 1 | Level-sensitive maskable request |
| nmiReq | input | 1 | Edge-triggered non-maskable request |
| intAccept | output | 1 | One-cycle strobe: maskable interrupt taken |
| nmiAccept | output | 1 | One-cycle strobe: NMI taken |
| pvFlag | output | 1 | Parity/overflow value produced by the load from I/R |

## Verification
Each decision is made at the rising edge that closes a cycle with `instrDone` high. Both accept strobes and any new `pvFlag` value therefore become visible exactly one cycle after the boundary is presented. An NMI edge must first be latched at one rising edge before a later boundary can take it. The bench presents each boundary on a falling edge and samples the outputs just after the next rising edge. Its expected values come from a step-by-step model of the enables and the NMI latch, kept separately for both settings of the defect parameter.

// File: rtl/irqen_pkg.sv
package irqen_pkg;
  // Decisions made by the control for one boundary, applied by the datapath.
  typedef struct packed {
    logic commit;     // an instruction completes: apply its effect on enables
    logic takeInt;    // maskable interrupt accepted here
    logic takeNmi;    // non-maskable interrupt accepted here
    logic capturePv;  // load from I/R completes: capture P/V
  } bndStrobe_t;
endpackage

// File: rtl/irqen_ctrl.sv
module irqen_ctrl
  import irqen_pkg::*;
(
  input  logic       clk,
  input  logic       rstN,
  input  logic       instrDone,
  input  logic       isEi,
  input  logic       isLdAir,
  input  logic       intReq,
  input  logic       nmiReq,
  input  logic       effIff1,
  output logic       nmiPending,
  output bndStrobe_t stb
);
  logic nmiPrev;
  logic nmiRise;

  assign nmiRise = nmiReq & ~nmiPrev;

  always_comb begin
    stb.commit    = instrDone;
    stb.takeNmi   = instrDone & nmiPending;
    // EI shadow: the boundary ending EI never accepts a maskable request
    stb.takeInt   = instrDone & intReq & effIff1 & ~isEi & ~stb.takeNmi;
    stb.capturePv = instrDone & isLdAir;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      nmiPrev    <= 1'b0;
      nmiPending <= 1'b0;
    end else begin
      nmiPrev    <= nmiReq;
      // a new edge in the same cycle as acceptance stays latched
      nmiPending <= (nmiPending & ~stb.takeNmi) | nmiRise;
    end
  end
endmodule

// File: rtl/irqen_datapath.sv
module irqen_datapath
  import irqen_pkg::*;
#(
  parameter bit NMOS_BUG = 1'b1
) (
  input  logic       clk,
  input  logic       rstN,
  input  logic       isEi,
  input  logic       isDi,
  input  logic       isRetn,
  input  bndStrobe_t stb,
  output logic       effIff1,
  output logic       iff1Q,
  output logic       iff2Q,
  output logic       intAcceptQ,
  output logic       nmiAcceptQ,
  output logic       pvQ
);
  logic effIff2;
  logic pvNext;

  // Enable state as the completing instruction leaves it
  always_comb begin
    if (isDi) begin
      effIff1 = 1'b0;
      effIff2 = 1'b0;
    end else if (isEi) begin
      effIff1 = 1'b1;
      effIff2 = 1'b1;
    end else if (isRetn) begin
      effIff1 = iff2Q;
      effIff2 = iff2Q;
    end else begin
      effIff1 = iff1Q;
      effIff2 = iff2Q;
    end
  end

  generate
    if (NMOS_BUG) begin : g_pvDefect
      assign pvNext = iff2Q & ~stb.takeInt;
    end else begin : g_pvTrue
      assign pvNext = iff2Q;
    end
  endgenerate

  always_ff @(posedge clk) begin
    if (!rstN) begin
      iff1Q      <= 1'b0;
      iff2Q      <= 1'b0;
      intAcceptQ <= 1'b0;
      nmiAcceptQ <= 1'b0;
      pvQ        <= 1'b0;
    end else begin
      intAcceptQ <= stb.takeInt;
      nmiAcceptQ <= stb.takeNmi;
      if (stb.capturePv) pvQ <= pvNext;
      if (stb.takeNmi) begin
        iff2Q <= effIff1;
        iff1Q <= 1'b0;
      end else if (stb.takeInt) begin
        iff1Q <= 1'b0;
        iff2Q <= 1'b0;
      end else if (stb.commit) begin
        iff1Q <= effIff1;
        iff2Q <= effIff2;
      end
    end
  end
endmodule

// File: rtl/irq_enable_ctrl.sv
module irq_enable_ctrl
  import irqen_pkg::*;
#(
  parameter bit NMOS_BUG = 1'b1
) (
  input  logic clk,
  input  logic rstN,
  input  logic instrDone,
  input  logic isEi,
  input  logic isDi,
  input  logic isRetn,
  input  logic isLdAir,
  input  logic intReq,
  input  logic nmiReq,
  output logic intAccept,
  output logic nmiAccept,
  output logic pvFlag
);
  bndStrobe_t stb;
  logic effIff1;
  logic iff1Q;
  logic iff2Q;
  logic nmiPending;

  irqen_ctrl u_ctrl (
    .clk(clk), .rstN(rstN), .instrDone(instrDone), .isEi(isEi),
    .isLdAir(isLdAir), .intReq(intReq), .nmiReq(nmiReq),
    .effIff1(effIff1), .nmiPending(nmiPending), .stb(stb)
  );

  irqen_datapath #(.NMOS_BUG(NMOS_BUG)) u_dp (
    .clk(clk), .rstN(rstN), .isEi(isEi), .isDi(isDi), .isRetn(isRetn),
    .stb(stb), .effIff1(effIff1), .iff1Q(iff1Q), .iff2Q(iff2Q),
    .intAcceptQ(intAccept), .nmiAcceptQ(nmiAccept), .pvQ(pvFlag)
  );
endmodule

// File: rtl/irq_enable_ctrl_chk.sv
module irq_enable_ctrl_chk #(
  parameter bit NMOS_BUG = 1'b1
) (
  input logic clk,
  input logic rstN,
  input logic instrDone,
  input logic isEi,
  input logic isDi,
  input logic isLdAir,
  input logic intAccept,
  input logic nmiAccept,
  input logic pvFlag,
  input logic iff1Q,
  input logic iff2Q
);
  // R2
  ei_shadow_chk: assert property (@(posedge clk) disable iff (!rstN)
    (instrDone && isEi) |=> !intAccept);

  // R3
  di_block_chk: assert property (@(posedge clk) disable iff (!rstN)
    (instrDone && isDi) |=> (!intAccept && !iff1Q && !iff2Q));

  // R4
  int_clears_chk: assert property (@(posedge clk) disable iff (!rstN)
    intAccept |-> (!iff1Q && !iff2Q));

  // R6
  nmi_priority_chk: assert property (@(posedge clk) disable iff (!rstN)
    nmiAccept |-> !intAccept);

  // R7
  nmi_clears_chk: assert property (@(posedge clk) disable iff (!rstN)
    nmiAccept |-> !iff1Q);

  // R10
  pv_value_chk: assert property (@(posedge clk) disable iff (!rstN)
    (instrDone && isLdAir) |=>
      ((NMOS_BUG && intAccept) ? !pvFlag : (pvFlag == $past(iff2Q))));

  // R11
  no_boundary_chk: assert property (@(posedge clk) disable iff (!rstN)
    !instrDone |=> (!intAccept && !nmiAccept && $stable(iff1Q) && $stable(iff2Q)));
endmodule

bind irq_enable_ctrl irq_enable_ctrl_chk #(.NMOS_BUG(NMOS_BUG)) u_chk (
  .clk(clk), .rstN(rstN), .instrDone(instrDone), .isEi(isEi), .isDi(isDi),
  .isLdAir(isLdAir), .intAccept(intAccept), .nmiAccept(nmiAccept),
  .pvFlag(pvFlag), .iff1Q(iff1Q), .iff2Q(iff2Q)
);

// File: tb/irq_enable_ctrl_test.sv
module irq_enable_ctrl_test;
  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic instrDone = 1'b0, isEi = 1'b0, isDi = 1'b0, isRetn = 1'b0, isLdAir = 1'b0;
  logic intReq = 1'b0, nmiReq = 1'b0;
  logic intA, nmiA, pvB, intF, nmiF, pvF;
  int checks = 0;
  int errors = 0;
  bit finished = 1'b0;

  // model state
  bit m1, m2, mPend, mPrev, eInt, eNmi, ePvB, ePvF;

  always #5 clk = ~clk;

  irq_enable_ctrl #(.NMOS_BUG(1'b1)) uut (
    .clk(clk), .rstN(rstN), .instrDone(instrDone), .isEi(isEi), .isDi(isDi),
    .isRetn(isRetn), .isLdAir(isLdAir), .intReq(intReq), .nmiReq(nmiReq),
    .intAccept(intA), .nmiAccept(nmiA), .pvFlag(pvB)
  );
  irq_enable_ctrl #(.NMOS_BUG(1'b0)) uutFix (
    .clk(clk), .rstN(rstN), .instrDone(instrDone), .isEi(isEi), .isDi(isDi),
    .isRetn(isRetn), .isLdAir(isLdAir), .intReq(intReq), .nmiReq(nmiReq),
    .intAccept(intF), .nmiAccept(nmiF), .pvFlag(pvF)
  );

  task automatic check(string tag, string what, bit act, bit exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s: actual=%0b expected=%0b", tag, what, act, exp);
    end
  endtask

  function automatic bit eff1(bit d, bit ei, bit di, bit rt, bit a, bit b);
    return d ? 1'b0 : (ei ? 1'b1 : (rt ? b : a));
  endfunction

  // op: 0 nop, 1 EI, 2 DI, 3 RETN, 4 LD A,I
  task automatic step(string tag, bit done, int op, bit intr, bit nmi);
    bit ei, di, rt, ld, e1, e2, tn, ti;
    @(negedge clk);
    ei = (op == 1); di = (op == 2); rt = (op == 3); ld = (op == 4);
    instrDone = done; isEi = ei; isDi = di; isRetn = rt; isLdAir = ld;
    intReq = intr; nmiReq = nmi;
    e1 = eff1(di, ei, di, rt, m1, m2);
    e2 = di ? 1'b0 : (ei ? 1'b1 : m2);
    tn = done && mPend;
    ti = done && intr && e1 && !ei && !tn;
    eInt = ti; eNmi = tn;
    if (done && ld) begin
      ePvB = ti ? 1'b0 : m2;
      ePvF = m2;
    end
    if (tn) begin m2 = e1; m1 = 1'b0; end
    else if (ti) begin m1 = 1'b0; m2 = 1'b0; end
    else if (done) begin m1 = e1; m2 = e2; end
    mPend = (mPend && !tn) || (nmi && !mPrev);
    mPrev = nmi;
    @(posedge clk);
    #2;
    check(tag, "intAccept", intA, eInt);
    check(tag, "intAccept(fixed)", intF, eInt);
    check(tag, "nmiAccept", nmiA, eNmi);
    check(tag, "nmiAccept(fixed)", nmiF, eNmi);
    check(tag, "pvFlag(defect)", pvB, ePvB);
    check(tag, "pvFlag(fixed)", pvF, ePvF);
  endtask

  initial begin : watchdog
    #(200000 * 10);
    if (!finished) begin
      errors++;
      checks++;
      $display("FAIL watchdog: actual=running expected=finished");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin : main
    int gap;
    void'($urandom(32'd1234));
    m1 = 0; m2 = 0; mPend = 0; mPrev = 0; ePvB = 0; ePvF = 0;
    repeat (3) @(posedge clk);
    #2;
    // R1 reset state
    check("R1", "intAccept", intA, 1'b0);
    check("R1", "nmiAccept", nmiA, 1'b0);
    check("R1", "pvFlag", pvB, 1'b0);
    @(negedge clk) rstN = 1'b1;
    step("R1", 1, 0, 1, 0);            // enables clear: no accept
    step("R1", 1, 4, 0, 0);            // shadow enable reads 0
    // R2 EI shadow then acceptance
    step("R2", 1, 1, 1, 0);
    step("R2", 1, 0, 1, 0);
    // R11 nothing happens without a boundary
    step("R11", 1, 1, 0, 0);
    step("R11", 0, 2, 1, 0);
    step("R11", 0, 0, 1, 0);
    step("R11", 1, 4, 0, 0);           // still enabled: pv 1
    // R3 DI blocks at its own boundary
    step("R3", 1, 2, 1, 0);
    step("R3", 1, 0, 1, 0);
    step("R3", 1, 4, 0, 0);
    // R5 EI;RET under continuous request
    step("R5", 1, 1, 1, 0);
    step("R5", 1, 0, 1, 0);            // accept after first instr
    step("R5", 1, 0, 1, 0);            // handler body
    step("R5", 1, 1, 1, 0);            // EI
    step("R5", 1, 0, 1, 0);            // RET: accepted at its end
    check("R5", "accept right after RET", intA, 1'b1);
    // R10 load from I coinciding with acceptance
    step("R10", 1, 1, 0, 0);
    step("R10", 1, 0, 0, 0);
    step("R10", 1, 4, 1, 0);
    check("R10", "pv defect reads 0", pvB, 1'b0);
    check("R10", "pv fixed reads 1", pvF, 1'b1);
    // R9 load without acceptance, held value
    step("R9", 1, 4, 0, 0);
    step("R9", 1, 0, 0, 0);
    // R6/R7/R8 NMI nesting and restore
    step("R6", 1, 1, 0, 0);
    step("R6", 1, 0, 0, 1);            // edge latched
    step("R6", 1, 0, 1, 1);            // NMI wins over INT
    step("R6", 1, 0, 1, 1);            // held high: no second NMI
    step("R7", 1, 4, 1, 0);            // shadow still 1, main 0
    step("R8", 1, 3, 1, 0);            // RETN restores: INT taken here
    step("R6", 1, 2, 0, 1);            // NMI edge with enables off
    step("R6", 1, 0, 0, 0);
    step("R7", 1, 4, 0, 0);
    step("R8", 1, 3, 1, 0);
    // R4 constrained random mix
    for (int i = 0; i < 3000; i++) begin
      gap = $urandom_range(0, 9);
      step("R4", gap < 6, (gap < 5) ? int'($urandom_range(0, 4)) : 0,
           $urandom_range(0, 2) != 0, $urandom_range(0, 7) == 0);
    end
    finished = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule